// File: doc/BRIEF.md
# Double-Edge Pixel Bus Demultiplexer

This block turns a narrow double-rate colour bus into whole pixels. Nine single-bit lanes, already resolved to logic levels, carry three colour channels of six bits each. Every lane delivers two bits per shift-clock period: one is presented around the rising edge and the other around the falling edge. The block joins the two halves and registers one 18-bit pixel on every falling edge.

A bus-wide inversion input flips every received bit. This covers boards where the positive and negative wires of the differential pairs are swapped. A start pulse, sampled on a falling edge, sets the alignment of the stream. The pixel completed on the next falling edge is discarded. Pixels are flagged valid from the second falling edge onward, but only on edges where the channel sequencer holds the enable input high.

Top module: `pxbus_demux`

## Requirements
- R1: While `rst` is high at a falling edge, `pixel_o` is cleared to zero and `pixel_valid` is deasserted at that edge. `rst` is synchronous and active high.
- R2: Lane index = 3*colour + pair, with colour 0 = red, 1 = green and 2 = blue, and pair 0..2. The bit seen at the rising edge becomes bit 6*colour + 2*pair of `pixel_o`. The bit seen at the following falling edge becomes bit 6*colour + 2*pair + 1. Red occupies `pixel_o[5:0]`, green `[11:6]` and blue `[17:12]`.
- R3: When `invert_i` is high at the edge where a half is sampled, every bit of that half is stored inverted. When it is low, the bits are stored unchanged.
- R4: `pixel_o` updates on every falling edge from the latest rising-edge half and the falling-edge half, whether or not the pixel is valid.
- R5: A start pulse is sampled on a falling edge. The pixel registered at that edge and the pixel registered at the next falling edge are not valid. The pixel registered at the second falling edge after the capture is valid if enable is high.
- R6: `pixel_valid` is high after a falling edge only if `enable_i` was high at that edge.
- R7: After a start, `pixel_valid` stays high for every falling edge at which enable is high. Each such edge produces exactly one valid pixel, lasting one clock period.
- R8: A start pulse arriving while pixels are already streaming restarts the alignment. The same two-edge blanking as in R5 then applies.
- R9: After reset and before any start pulse, `pixel_valid` stays low whatever `enable_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| lanes_i | input | 9 | Resolved data lanes, two bits per period |
| invert_i | input | 1 | High: every received bit is inverted |
| start_i | input | 1 | Stream alignment pulse, sampled on the falling edge |
| enable_i | input | 1 | Sequencer enable for the valid strobe, sampled on the falling edge |
| pixel_o | output | 18 | Assembled pixel {blue, green, red} |
| pixel_valid | output | 1 | One strobe per valid assembled pixel |

## Verification
Two functions can fall on the same falling edge. A restarting start pulse can coincide with a pixel that would otherwise be flagged valid. A drop of the sequencer enable can also land on the edge where blanking ends. The bench provokes the first case by raising start while a stream is running with enable high. It provokes the second by lowering enable exactly on the second edge after a start. In both cases it judges the result at the ports: the blanked and disabled pixels must carry no strobe, while `pixel_o` still shows the expected data word.

// File: rtl/pxbus_demux_pkg.sv
package pxbus_demux_pkg;
  typedef enum logic [1:0] {
    ALIGN_IDLE = 2'd0,
    ALIGN_SKIP = 2'd1,
    ALIGN_RUN  = 2'd2
  } align_state_t;
endpackage

// File: rtl/pxbus_rise_sampler.sv
module pxbus_rise_sampler #(
  parameter int LANES = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lanes_i,
  input  logic             invert_i,
  output logic [LANES-1:0] half_q
);
  logic [LANES-1:0] flip_mask;

  always_comb flip_mask = {LANES{invert_i}};

  always_ff @(posedge clk) begin
    if (rst) half_q <= '0;
    else     half_q <= lanes_i ^ flip_mask;
  end
endmodule

// File: rtl/pxbus_pixel_packer.sv
module pxbus_pixel_packer #(
  parameter int N_COLOURS = 3,
  parameter int CH_BITS   = 6,
  localparam int PAIRS    = CH_BITS / 2,
  localparam int LANES    = N_COLOURS * PAIRS,
  localparam int WORD     = N_COLOURS * CH_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] first_half_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic             invert_i,
  output logic [WORD-1:0]  pixel_q
);
  logic [LANES-1:0] second_half;
  logic [WORD-1:0]  joined;

  always_comb second_half = lanes_i ^ {LANES{invert_i}};

  for (genvar c = 0; c < N_COLOURS; c++) begin : g_colour
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign joined[c*CH_BITS + 2*p]     = first_half_i[c*PAIRS + p];
      assign joined[c*CH_BITS + 2*p + 1] = second_half[c*PAIRS + p];
    end
  end

  always_ff @(negedge clk) begin
    if (rst) pixel_q <= '0;
    else     pixel_q <= joined;
  end

  AST_RESET_CLEARS_WORD: assert property (@(negedge clk) rst |=> (pixel_q == '0)) // R1
    else $error("pixel word not cleared by reset");
endmodule

// File: rtl/pxbus_frame_aligner.sv
module pxbus_frame_aligner
  import pxbus_demux_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic enable_i,
  output logic valid_q
);
  align_state_t state_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      state_q <= ALIGN_IDLE;
      valid_q <= 1'b0;
    end else if (start_i) begin
      state_q <= ALIGN_SKIP;
      valid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ALIGN_IDLE: valid_q <= 1'b0;
        ALIGN_SKIP: begin
          state_q <= ALIGN_RUN;
          valid_q <= 1'b0;
        end
        ALIGN_RUN:  valid_q <= enable_i;
        default: begin
          state_q <= ALIGN_IDLE;
          valid_q <= 1'b0;
        end
      endcase
    end
  end

  AST_RESET_DROPS_VALID: assert property (@(negedge clk) rst |=> !valid_q) // R1
    else $error("valid survives reset");
  AST_VALID_NEEDS_ENABLE: assert property (@(negedge clk) disable iff (rst)
      valid_q |-> $past(enable_i)) // R6
    else $error("valid without enable");
  AST_START_BLANKS: assert property (@(negedge clk) disable iff (rst)
      start_i |=> !valid_q) // R5
    else $error("pixel at start edge flagged valid");
  AST_SECOND_EDGE_LIVE: assert property (@(negedge clk) disable iff (rst)
      ($past(start_i, 2) && !$past(start_i) && !start_i && enable_i) |=> valid_q) // R5
    else $error("second edge after start not valid");
endmodule

// File: rtl/pxbus_demux.sv
module pxbus_demux #(
  parameter int N_COLOURS = 3,
  parameter int CH_BITS   = 6,
  localparam int LANES    = N_COLOURS * (CH_BITS / 2),
  localparam int WORD     = N_COLOURS * CH_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lanes_i,
  input  logic             invert_i,
  input  logic             start_i,
  input  logic             enable_i,
  output logic [WORD-1:0]  pixel_o,
  output logic             pixel_valid
);
  logic [LANES-1:0] first_half;

  pxbus_rise_sampler #(.LANES(LANES)) u_rise (
    .clk      (clk),
    .rst      (rst),
    .lanes_i  (lanes_i),
    .invert_i (invert_i),
    .half_q   (first_half)
  );

  pxbus_pixel_packer #(.N_COLOURS(N_COLOURS), .CH_BITS(CH_BITS)) u_pack (
    .clk          (clk),
    .rst          (rst),
    .first_half_i (first_half),
    .lanes_i      (lanes_i),
    .invert_i     (invert_i),
    .pixel_q      (pixel_o)
  );

  pxbus_frame_aligner u_align (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .enable_i (enable_i),
    .valid_q  (pixel_valid)
  );

  AST_PIXEL_FROM_RISE_HALF: assert property (@(negedge clk) disable iff (rst)
      1'b1 |=> (pixel_o[0] == $past(first_half[0]))) // R2
    else $error("red bit 0 not taken from rising half");
endmodule

// File: tb/pxbus_demux_test.sv
module pxbus_demux_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  lanes_i = '0;
  logic        invert_i = 1'b0;
  logic        start_i = 1'b0;
  logic        enable_i = 1'b0;
  logic [17:0] pixel_o;
  logic        pixel_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxbus_demux uut (
    .clk(clk), .rst(rst), .lanes_i(lanes_i), .invert_i(invert_i),
    .start_i(start_i), .enable_i(enable_i),
    .pixel_o(pixel_o), .pixel_valid(pixel_valid)
  );

  function automatic logic [8:0] enc(input logic [17:0] pix, input int half);
    logic [8:0] l;
    for (int c = 0; c < 3; c++)
      for (int p = 0; p < 3; p++)
        l[c*3+p] = pix[c*6 + 2*p + half];
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one pixel period starting at falling edge + 3; returns outputs at the next falling edge + 2.
  task automatic slot(input logic [17:0] pix, input logic inv, input logic en, input logic st,
                      output logic [17:0] got, output logic gv);
    lanes_i = enc(pix, 0); invert_i = inv; enable_i = en; start_i = st;
    @(posedge clk); #3;
    lanes_i = enc(pix, 1);
    @(negedge clk); #2;
    got = pixel_o; gv = pixel_valid;
    #1;
    start_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(pixel_o == '0, "R1 word", pixel_o, '0);
    check(pixel_valid == 1'b0, "R1 valid", {17'b0, pixel_valid}, 18'd0);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_no_start();
    logic [17:0] g; logic v;
    slot(18'h2A5C3, 1'b0, 1'b1, 1'b0, g, v);
    check(g == 18'h2A5C3, "R4 word without start", g, 18'h2A5C3);
    check(v == 1'b0, "R9 no valid before start", {17'b0, v}, 18'd0);
    slot(18'h15A3C, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b0, "R9 still no valid", {17'b0, v}, 18'd0);
  endtask

  task automatic t_start_align();
    logic [17:0] g; logic v;
    slot(18'h00111, 1'b0, 1'b1, 1'b1, g, v);
    check(v == 1'b0, "R5 start edge blank", {17'b0, v}, 18'd0);
    slot(18'h00222, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b0, "R5 first edge after start blank", {17'b0, v}, 18'd0);
    check(g == 18'h00222, "R4 word while blank", g, 18'h00222);
    slot(18'h3C0F5, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b1, "R5 second edge valid", {17'b0, v}, 18'd1);
    check(g == 18'h3C0F5, "R2 first valid word", g, 18'h3C0F5);
    slot(18'h3FFFF, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b1 && g == 18'h3FFFF, "R7 stream continues", g, 18'h3FFFF);
  endtask

  task automatic t_bit_map();
    logic [17:0] g; logic v;
    for (int b = 0; b < 18; b++) begin
      slot(18'd1 << b, 1'b0, 1'b1, 1'b0, g, v);
      check(g == (18'd1 << b) && v, "R2 walking bit", g, 18'd1 << b);
    end
  endtask

  task automatic t_invert();
    logic [17:0] g; logic v;
    slot(18'h0F0F0, 1'b1, 1'b1, 1'b0, g, v);
    check(g == ~18'h0F0F0, "R3 inverted word", g, ~18'h0F0F0);
    slot(18'h00000, 1'b1, 1'b1, 1'b0, g, v);
    check(g == 18'h3FFFF, "R3 zeros inverted", g, 18'h3FFFF);
    slot(18'h12345, 1'b0, 1'b1, 1'b0, g, v);
    check(g == 18'h12345, "R3 inversion off", g, 18'h12345);
  endtask

  task automatic t_enable();
    logic [17:0] g; logic v;
    slot(18'h0ABCD, 1'b0, 1'b0, 1'b0, g, v);
    check(v == 1'b0, "R6 enable low", {17'b0, v}, 18'd0);
    check(g == 18'h0ABCD, "R4 word with enable low", g, 18'h0ABCD);
    slot(18'h1DCBA, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b1, "R7 enable restored", {17'b0, v}, 18'd1);
  endtask

  task automatic t_restart();
    logic [17:0] g; logic v;
    slot(18'h11111, 1'b0, 1'b1, 1'b1, g, v);
    check(v == 1'b0, "R8 restart edge blank", {17'b0, v}, 18'd0);
    slot(18'h22222, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b0, "R8 restart second blank", {17'b0, v}, 18'd0);
    slot(18'h33333, 1'b0, 1'b0, 1'b0, g, v);
    check(v == 1'b0, "R6 enable low on release edge", {17'b0, v}, 18'd0);
    check(g == 18'h33333, "R4 word on release edge", g, 18'h33333);
    slot(18'h04444, 1'b0, 1'b1, 1'b0, g, v);
    check(v == 1'b1 && g == 18'h04444, "R8 stream resumes", g, 18'h04444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3;
    do_reset();
    t_no_start();
    t_start_align();
    t_bit_map();
    t_invert();
    t_enable();
    t_restart();
    do_reset();
    t_no_start();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule